// File: doc/BRIEF.md
# Configurable SPI Master/Slave Port

This block is a synchronous serial port of parameterised byte width (8 bits by default). It runs either as the clock-generating master or as a slave clocked from an external SCK. Each transfer moves one word out on SDO and one word in from SDI at the same time, most significant bit first. Two shift registers, one for transmit and one for receive, do the bit-level work. The host sees one buffer address. A write loads the transmit shift register and starts the transfer. The received word moves into the read buffer when the transfer completes.

A 4-bit mode input picks the operating mode and, for the master, the clock source. Three control bits set the clock idle level, the edge that launches data, and whether the master samples SDI in the middle or at the end of each bit time. Three sticky flags report the buffer state, write collisions and receive overruns. Because the transmit and receive paths are separate, a new transfer can start while the previous received word is still unread.

Top module: `spi_port`

## Requirements
- R1: After reset, buf_full, wr_coll, rx_ovf and busy are 0 and rdata is 0.
- R2: A master transfer drives exactly 8 SCK pulses. It shifts the written word out on SDO and the SDI word into rdata, both most significant bit first and on the same clock.
- R3: cfg_cpol sets the SCK idle level. With cfg_cke=1, the first bit is on SDO before the first edge, SDI is sampled on each leading edge (the edge leaving idle), and the next bit is launched on each trailing edge. With cfg_cke=0, bits are launched on leading edges and SDI is sampled on trailing edges. All four combinations of cfg_cpol and cfg_cke work.
- R4: cfg_mode values 0, 1 and 2 select a master with an SCK half-period of 2, 8 and 32 clk cycles (clk divided by 4, 16 and 64). Value 3 selects a master whose SCK toggles once per timer_tick pulse. Value 4 selects a slave that uses ss_n. Value 5 selects a slave that ignores ss_n. Any other value is disabled: writes start nothing and sdo_oe is 0.
- R5: With cfg_smp=1, the master samples SDI one SCK half-period later than with cfg_smp=0, at the end of the bit time. This includes one extra half-period after the last edge.
- R6: A write while the port is idle and enabled starts a transfer. At completion the received word appears on rdata and buf_full becomes 1.
- R7: An rd_en pulse clears buf_full.
- R8: A write while busy is 1 is discarded and sets wr_coll. The transfer in progress keeps its data. clr_flags clears wr_coll and rx_ovf.
- R9: If a transfer completes while buf_full is 1 and no read occurs in that cycle, rx_ovf sets and rdata keeps the older word.
- R10: In slave mode, transfers follow sck_in using the same cfg_cpol/cfg_cke rules as R3. Inputs are synchronised with a two-stage register.
- R11: In mode 4, sdo_oe is 0 while ss_n is high. A high ss_n clears the slave bit counter, so a partial transfer is abandoned and busy returns to 0.
- R12: In mode 5, ss_n has no effect: sdo_oe stays 1 and transfers complete with ss_n held high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_mode | input | 4 | Mode and master clock source select |
| cfg_cpol | input | 1 | SCK idle level |
| cfg_cke | input | 1 | 1: launch on trailing edge, 0: launch on leading edge |
| cfg_smp | input | 1 | Master sample point: 0 middle, 1 end of bit time |
| wr_en | input | 1 | Buffer write strobe |
| wdata | input | DW | Word to transmit |
| rd_en | input | 1 | Buffer read strobe, clears buf_full |
| clr_flags | input | 1 | Clears wr_coll and rx_ovf |
| rdata | output | DW | Received word buffer |
| buf_full | output | 1 | Unread word in buffer |
| wr_coll | output | 1 | Write collision flag |
| rx_ovf | output | 1 | Receive overrun flag |
| busy | output | 1 | Transfer in progress |
| timer_tick | input | 1 | External timer pulse for mode 3 |
| sck_out | output | 1 | Master serial clock |
| sck_in | input | 1 | Slave serial clock |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | SDO output enable (0 = high impedance) |
| sdi | input | 1 | Serial data in |
| ss_n | input | 1 | Slave select, active low |

## Verification
The bench builds the port with its default parameters: an 8-bit word and dividers of 4, 16 and 64. These are small enough that even a divide-by-64 master transfer, 17 half-periods of 32 cycles, fits comfortably in the run. The bench also measures every master clock source against its half-period. A behavioural slave peer that can launch its bits late makes the two sample points give different results. A bench-driven master, together with ss_n toggling part-way through a word, reaches the slave counter reset.

// File: rtl/spi_port_pkg.sv
// Package: shared mode codes for the serial port.
// Assumes: cfg_mode is 4 bits; unlisted codes mean "disabled".
package spi_port_pkg;
    typedef enum logic [3:0] {
        MODE_M_DIVA = 4'd0,
        MODE_M_DIVB = 4'd1,
        MODE_M_DIVC = 4'd2,
        MODE_M_TMR  = 4'd3,
        MODE_S_SEL  = 4'd4,
        MODE_S_FREE = 4'd5
    } port_mode_e;
endpackage

// File: rtl/spi_clkgen.sv
// Module: spi_clkgen
// Makes one "step" pulse per SCK half-period while a master transfer runs.
// Assumes: DIV_A < DIV_B < DIV_C, all even and >= 4; sel 3 uses timer_tick.
module spi_clkgen #(
    parameter int DIV_A = 4,
    parameter int DIV_B = 16,
    parameter int DIV_C = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [1:0] sel,
    input  logic       timer_tick,
    output logic       step
);
    localparam int HA = DIV_A / 2;
    localparam int HB = DIV_B / 2;
    localparam int HC = DIV_C / 2;
    localparam int CW = $clog2(HC + 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] lim;

    // Pick the terminal count of the half-period counter.
    always_comb begin
        case (sel)
            2'd0:    lim = CW'(HA - 1);
            2'd1:    lim = CW'(HB - 1);
            default: lim = CW'(HC - 1);
        endcase
    end

    assign step = run && ((sel == 2'd3) ? timer_tick : (cnt == lim));

    // Count system cycles within a half-period.
    always_ff @(posedge clk) begin
        if (!rst_n)        cnt <= '0;
        else if (!run)     cnt <= '0;
        else if (step)     cnt <= '0;
        else if (sel != 2'd3) cnt <= cnt + 1'b1;
    end

    // R4: divided clock never steps on two cycles in a row
    p_step_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (run && sel != 2'd3 && step) |=> !step);
endmodule

// File: rtl/spi_engine.sv
// Module: spi_engine
// Bit engine: master step sequencer, slave edge follower, tx/rx shifters.
// Assumes: configuration is stable during a transfer; load only when idle.
module spi_engine #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          is_master,
    input  logic          is_slave,
    input  logic          ss_use,
    input  logic          cpol,
    input  logic          cke,
    input  logic          smp,
    input  logic          load,
    input  logic [DW-1:0] load_data,
    input  logic          step,
    input  logic          sck_in,
    input  logic          sdi,
    input  logic          ss_n,
    output logic          run,
    output logic          sck_out,
    output logic          sdo,
    output logic          sdo_oe,
    output logic          busy,
    output logic          done,
    output logic [DW-1:0] rx_word
);
    localparam int KW  = $clog2(2 * DW + 2);
    localparam int CNW = $clog2(DW);
    localparam logic [KW-1:0] K_LAST = KW'(2 * DW);
    localparam logic [KW-1:0] K_END  = KW'(2 * DW + 1);
    localparam logic [KW-1:0] K_PRE  = KW'(2 * DW - 1);
    localparam logic [KW-1:0] K_PRE2 = KW'(2 * DW - 2);
    localparam logic [KW-1:0] K_TWO  = KW'(2);
    localparam logic [KW-1:0] K_THR  = KW'(3);

    logic [DW-1:0]  tx_sr;
    logic [KW-1:0]  k;
    logic [KW-1:0]  kn;
    logic           sck_r;
    logic [CNW-1:0] cnt;
    logic [2:0]     s_sck;
    logic [1:0]     s_sdi;
    logic [1:0]     s_ss;
    logic           m_smp_mid, m_smp_end, m_sample, m_launch;
    logic           s_edge, s_lead, s_trail, s_sample, s_launch, ss_act;

    assign kn = k + 1'b1;

    // Master: which half-steps sample SDI and which launch the next bit.
    always_comb begin
        m_smp_mid = cke ? (kn[0] && kn <= K_PRE)
                        : (!kn[0] && kn >= K_TWO && kn <= K_LAST);
        m_smp_end = cke ? (!kn[0] && kn >= K_TWO && kn <= K_LAST)
                        : (kn[0] && kn >= K_THR && kn <= K_END);
        m_sample  = smp ? m_smp_end : m_smp_mid;
        m_launch  = cke ? (!kn[0] && kn >= K_TWO && kn <= K_PRE2)
                        : (kn[0] && kn >= K_THR && kn <= K_PRE);
    end

    // Slave: classify synchronised SCK transitions.
    always_comb begin
        ss_act   = !ss_use || !s_ss[1];
        s_edge   = s_sck[1] ^ s_sck[2];
        s_lead   = s_edge && (s_sck[1] != cpol);
        s_trail  = s_edge && (s_sck[1] == cpol);
        s_sample = cke ? s_lead : s_trail;
        s_launch = (cke ? s_trail : s_lead) && (cnt != '0);
    end

    // Two-stage synchronisers for the slave-side pins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_sck <= {3{cpol}};
            s_sdi <= '0;
            s_ss  <= 2'b11;
        end else begin
            s_sck <= {s_sck[1:0], sck_in};
            s_sdi <= {s_sdi[0], sdi};
            s_ss  <= {s_ss[0], ss_n};
        end
    end

    // Transfer sequencing and shifting for both roles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_sr   <= '0;
            rx_word <= '0;
            run     <= 1'b0;
            k       <= '0;
            sck_r   <= 1'b0;
            cnt     <= '0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!is_slave) cnt <= '0;
            if (load) begin
                tx_sr <= load_data;
                if (is_master) begin
                    run   <= 1'b1;
                    k     <= '0;
                    sck_r <= cpol;
                end
            end else if (is_master) begin
                if (run && step) begin
                    k <= kn;
                    if (kn <= K_LAST) sck_r <= ~sck_r;
                    if (m_sample) rx_word <= {rx_word[DW-2:0], sdi};
                    if (m_launch) tx_sr <= {tx_sr[DW-2:0], 1'b0};
                    if (kn == K_END) begin
                        run  <= 1'b0;
                        done <= 1'b1;
                    end
                end
            end else if (is_slave) begin
                if (!ss_act) begin
                    cnt <= '0;
                end else begin
                    if (s_sample) begin
                        rx_word <= {rx_word[DW-2:0], s_sdi[1]};
                        if (cnt == CNW'(DW - 1)) begin
                            cnt  <= '0;
                            done <= 1'b1;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    if (s_launch) tx_sr <= {tx_sr[DW-2:0], 1'b0};
                end
            end
        end
    end

    assign sck_out = run ? sck_r : cpol;
    assign sdo     = tx_sr[DW-1];
    assign sdo_oe  = is_master || (is_slave && ss_act);
    assign busy    = is_master ? run : (cnt != '0);

    // R2: the last half-step of a master word ends the transfer
    p_word_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (is_master && run && step && k == K_LAST && !load) |=> (done && !run));
    // R3: every clocking half-step before the last flips SCK
    p_sck_toggle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (is_master && run && step && k < K_LAST && !load) |=> (sck_out != $past(sck_out)));
    // R11: deselected slave holds its bit counter at zero
    p_ss_reset_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (is_slave && ss_use && s_ss[1]) |=> (cnt == '0));
endmodule

// File: rtl/spi_bufctl.sv
// Module: spi_bufctl
// Receive buffer and sticky status flags.
// Assumes: done is a one-cycle pulse with rx_word valid in that cycle.
module spi_bufctl #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          done,
    input  logic [DW-1:0] rx_word,
    input  logic          rd_en,
    input  logic          wr_en,
    input  logic          busy,
    input  logic          clr_flags,
    output logic [DW-1:0] rdata,
    output logic          full,
    output logic          coll,
    output logic          ovf
);
    // Land received words, keep the old one on overrun.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
            full  <= 1'b0;
            ovf   <= 1'b0;
        end else begin
            if (done && (!full || rd_en)) begin
                rdata <= rx_word;
                full  <= 1'b1;
            end else if (done) begin
                ovf <= 1'b1;
            end else if (rd_en) begin
                full <= 1'b0;
            end
            if (clr_flags && !(done && full && !rd_en)) ovf <= 1'b0;
        end
    end

    // Flag writes that arrive during a transfer.
    always_ff @(posedge clk) begin
        if (!rst_n)              coll <= 1'b0;
        else if (wr_en && busy)  coll <= 1'b1;
        else if (clr_flags)      coll <= 1'b0;
    end

    // R9: overrun keeps the older word
    p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && full && !rd_en) |=> (ovf && $stable(rdata)));
    // R7: buffer-full only drops after a read
    p_full_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(full) |-> $past(rd_en));
    // R8: write during transfer raises the collision flag
    p_coll_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && busy) |=> coll);
endmodule

// File: rtl/spi_port.sv
// Module: spi_port (top)
// Configurable SPI master/slave port: mode decode and submodule wiring.
// Assumes: cfg_* inputs change only while busy is 0.
module spi_port
    import spi_port_pkg::*;
#(
    parameter int DW    = 8,
    parameter int DIV_A = 4,
    parameter int DIV_B = 16,
    parameter int DIV_C = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [3:0]    cfg_mode,
    input  logic          cfg_cpol,
    input  logic          cfg_cke,
    input  logic          cfg_smp,
    input  logic          wr_en,
    input  logic [DW-1:0] wdata,
    input  logic          rd_en,
    input  logic          clr_flags,
    output logic [DW-1:0] rdata,
    output logic          buf_full,
    output logic          wr_coll,
    output logic          rx_ovf,
    output logic          busy,
    input  logic          timer_tick,
    output logic          sck_out,
    input  logic          sck_in,
    output logic          sdo,
    output logic          sdo_oe,
    input  logic          sdi,
    input  logic          ss_n
);
    logic          is_master, is_slave, ss_use, load, step, run, done;
    logic [DW-1:0] rx_word;

    // Decode the mode field.
    always_comb begin
        is_master = (cfg_mode == MODE_M_DIVA) || (cfg_mode == MODE_M_DIVB) ||
                    (cfg_mode == MODE_M_DIVC) || (cfg_mode == MODE_M_TMR);
        is_slave  = (cfg_mode == MODE_S_SEL) || (cfg_mode == MODE_S_FREE);
        ss_use    = (cfg_mode == MODE_S_SEL);
        load      = wr_en && !busy && (is_master || is_slave);
    end

    spi_clkgen #(.DIV_A(DIV_A), .DIV_B(DIV_B), .DIV_C(DIV_C)) u_clkgen (
        .clk(clk), .rst_n(rst_n), .run(run), .sel(cfg_mode[1:0]),
        .timer_tick(timer_tick), .step(step)
    );

    spi_engine #(.DW(DW)) u_engine (
        .clk(clk), .rst_n(rst_n), .is_master(is_master), .is_slave(is_slave),
        .ss_use(ss_use), .cpol(cfg_cpol), .cke(cfg_cke), .smp(cfg_smp),
        .load(load), .load_data(wdata), .step(step), .sck_in(sck_in),
        .sdi(sdi), .ss_n(ss_n), .run(run), .sck_out(sck_out), .sdo(sdo),
        .sdo_oe(sdo_oe), .busy(busy), .done(done), .rx_word(rx_word)
    );

    spi_bufctl #(.DW(DW)) u_bufctl (
        .clk(clk), .rst_n(rst_n), .done(done), .rx_word(rx_word),
        .rd_en(rd_en), .wr_en(wr_en), .busy(busy), .clr_flags(clr_flags),
        .rdata(rdata), .full(buf_full), .coll(wr_coll), .ovf(rx_ovf)
    );
endmodule

// File: tb/spi_port_bench.sv
module spi_port_bench;
    localparam int CLK_PERIOD = 10;
    localparam int H = 8;

    logic       clk = 0;
    logic       rst_n = 0;
    logic [3:0] cfg_mode = 4'd0;
    logic       cfg_cpol = 0, cfg_cke = 0, cfg_smp = 0;
    logic       wr_en = 0, rd_en = 0, clr_flags = 0;
    logic [7:0] wdata = 0;
    logic [7:0] rdata;
    logic       buf_full, wr_coll, rx_ovf, busy;
    logic       timer_tick = 0, tick_on = 0;
    logic       sck_out, sck_in = 0, sdo, sdo_oe, sdi = 0, ss_n = 1;

    int total = 0, bad = 0, cyc = 0, tdiv = 0;
    bit finished = 0;
    logic [7:0] exp_q[$];
    logic prev_full = 0;

    spi_port u_spi_port (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_cpol(cfg_cpol),
        .cfg_cke(cfg_cke), .cfg_smp(cfg_smp), .wr_en(wr_en), .wdata(wdata),
        .rd_en(rd_en), .clr_flags(clr_flags), .rdata(rdata), .buf_full(buf_full),
        .wr_coll(wr_coll), .rx_ovf(rx_ovf), .busy(busy), .timer_tick(timer_tick),
        .sck_out(sck_out), .sck_in(sck_in), .sdo(sdo), .sdo_oe(sdo_oe),
        .sdi(sdi), .ss_n(ss_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Timer pulse: one cycle in five.
    always @(negedge clk) begin
        tdiv = (tdiv == 4) ? 0 : tdiv + 1;
        timer_tick <= tick_on && (tdiv == 0);
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: each new buffered word is compared with the scoreboard (R6).
    always @(negedge clk) begin
        if (rst_n && buf_full && !prev_full) begin
            if (exp_q.size() == 0) chk(0, "R6 unexpected word", rdata, 0);
            else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                chk(rdata == e, "R6 received word", rdata, e);
            end
        end
        prev_full = buf_full;
    end

    task automatic write_buf(input logic [7:0] b);
        @(negedge clk); wr_en = 1; wdata = b;
        @(negedge clk); wr_en = 0;
    endtask

    task automatic read_buf();
        @(negedge clk); rd_en = 1;
        @(negedge clk); rd_en = 0;
    endtask

    task automatic clear_flags();
        @(negedge clk); clr_flags = 1;
        @(negedge clk); clr_flags = 0;
    endtask

    // Bench acts as slave peer for a master transfer.
    task automatic master_xfer(input logic [7:0] mtx, input logic [7:0] ptx,
                               input bit late, output logic [7:0] pgot,
                               output int half);
        int e, idx, t1, t0;
        bit prev, lead, chg, cap;
        e = 0; idx = 0; t1 = 0; half = 0; pgot = 0;
        if (!late && cfg_cke) begin sdi = ptx[7]; idx = 1; end
        write_buf(mtx);
        prev = sck_out;
        t0 = cyc;
        while (e < 16 && cyc - t0 < 20000) begin
            @(negedge clk);
            if (sck_out != prev) begin
                prev = sck_out;
                e++;
                if (e == 1) t1 = cyc;
                if (e == 2) half = cyc - t1;
                lead = (sck_out != cfg_cpol);
                chg  = late ? (cfg_cke ? lead : !lead) : (cfg_cke ? !lead : lead);
                cap  = cfg_cke ? lead : !lead;
                if (chg && idx < 8) begin sdi = ptx[7-idx]; idx++; end
                if (cap) pgot = {pgot[6:0], sdo};
            end
        end
        while (busy && cyc - t0 < 20000) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    // Bench acts as master driving the slave port.
    task automatic drive_slave(input logic [7:0] mtx, input int nbits,
                               input bit use_ss, output logic [7:0] got);
        got = 0;
        if (use_ss) ss_n = 0;
        repeat (4) @(negedge clk);
        if (cfg_cke) begin
            sdi = mtx[7];
            repeat (H) @(negedge clk);
            for (int i = 0; i < nbits; i++) begin
                got = {got[6:0], sdo};
                sck_in = ~cfg_cpol;
                repeat (H) @(negedge clk);
                sck_in = cfg_cpol;
                if (i < 7) sdi = mtx[6-i];
                repeat (H) @(negedge clk);
            end
        end else begin
            for (int i = 0; i < nbits; i++) begin
                sck_in = ~cfg_cpol;
                sdi = mtx[7-i];
                repeat (H) @(negedge clk);
                got = {got[6:0], sdo};
                sck_in = cfg_cpol;
                repeat (H) @(negedge clk);
            end
        end
        repeat (6) @(negedge clk);
        if (use_ss) ss_n = 1;
        repeat (4) @(negedge clk);
    endtask

    task automatic set_slave(input logic [3:0] m, input bit pol, input bit ke);
        @(negedge clk); cfg_mode = 4'hF; cfg_cpol = pol; cfg_cke = ke; sck_in = pol;
        repeat (5) @(negedge clk);
        cfg_mode = m;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 200000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] got;
        int half;
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(!buf_full && !wr_coll && !rx_ovf && !busy, "R1 flags",
            {buf_full, wr_coll, rx_ovf, busy}, 0);
        chk(rdata == 8'h00, "R1 rdata", rdata, 0);

        // R2/R3: four polarity/edge combinations, divide-by-4
        for (int c = 0; c < 4; c++) begin
            logic [7:0] m, p;
            cfg_cpol = c[1]; cfg_cke = c[0];
            m = 8'hA5 ^ 8'(c * 8'h1B);
            p = 8'h3C + 8'(c * 8'h47);
            @(negedge clk);
            chk(sck_out == cfg_cpol, "R3 idle level", sck_out, cfg_cpol);
            exp_q.push_back(p);
            master_xfer(m, p, 0, got, half);
            chk(got == m, "R2 R3 peer received", got, m);
            if (c == 0) chk(half == 2, "R4 div4 half period", half, 2);
            read_buf();
            chk(!buf_full, "R7 read clears full", buf_full, 0);
        end

        // R4: other clock sources
        cfg_cpol = 0; cfg_cke = 1;
        cfg_mode = 4'd1; exp_q.push_back(8'h81);
        master_xfer(8'h7E, 8'h81, 0, got, half);
        chk(half == 8, "R4 div16 half period", half, 8);
        read_buf();
        cfg_mode = 4'd2; exp_q.push_back(8'h19);
        master_xfer(8'hC3, 8'h19, 0, got, half);
        chk(half == 32, "R4 div64 half period", half, 32);
        chk(got == 8'hC3, "R2 div64 data", got, 8'hC3);
        read_buf();
        cfg_mode = 4'd3; tick_on = 1; exp_q.push_back(8'h66);
        master_xfer(8'h5A, 8'h66, 0, got, half);
        chk(half == 5, "R4 timer half period", half, 5);
        tick_on = 0;
        read_buf();

        // R5: late sampling with a peer that changes data at mid-bit
        cfg_mode = 4'd0; cfg_smp = 1;
        for (int c = 0; c < 2; c++) begin
            cfg_cke = c[0];
            exp_q.push_back(8'hB2 ^ 8'(c));
            master_xfer(8'h0F, 8'hB2 ^ 8'(c), 1, got, half);
            chk(got == 8'h0F, "R5 late peer received", got, 8'h0F);
            read_buf();
        end
        cfg_smp = 0; cfg_cke = 0;

        // R8: write collision
        exp_q.push_back(8'h44);
        fork
            master_xfer(8'hE1, 8'h44, 0, got, half);
            begin
                repeat (12) @(negedge clk);
                wr_en = 1; wdata = 8'h12;
                @(negedge clk); wr_en = 0;
            end
        join
        chk(wr_coll, "R8 collision flag", wr_coll, 1);
        chk(got == 8'hE1, "R8 discarded write", got, 8'hE1);
        read_buf();
        clear_flags();
        chk(!wr_coll, "R8 flag cleared", wr_coll, 0);

        // R9: overrun keeps old word
        exp_q.push_back(8'h91);
        master_xfer(8'h00, 8'h91, 0, got, half);
        master_xfer(8'h00, 8'h2D, 0, got, half);
        chk(rx_ovf, "R9 overrun flag", rx_ovf, 1);
        chk(rdata == 8'h91, "R9 old word kept", rdata, 8'h91);
        read_buf();
        clear_flags();
        chk(!rx_ovf, "R9 flag cleared", rx_ovf, 0);

        // R4: disabled mode
        cfg_mode = 4'hF;
        write_buf(8'hFF);
        repeat (2) @(negedge clk);
        chk(!busy && !sdo_oe, "R4 disabled mode", {busy, sdo_oe}, 0);

        // R10/R11: slave with select
        for (int c = 0; c < 4; c++) begin
            logic [7:0] s, m;
            s = 8'hD4 ^ 8'(c * 8'h21);
            m = 8'h2B + 8'(c * 8'h35);
            set_slave(4'd4, c[1], c[0]);
            repeat (3) @(negedge clk);
            chk(!sdo_oe, "R11 sdo released", sdo_oe, 0);
            write_buf(s);
            exp_q.push_back(m);
            drive_slave(m, 8, 1, got);
            chk(got == s, "R10 slave sent", got, s);
            read_buf();
        end

        // R11: partial word abandoned on deselect
        set_slave(4'd4, 0, 1);
        write_buf(8'h77);
        drive_slave(8'hAA, 3, 1, got);
        chk(!busy, "R11 counter reset", busy, 0);
        write_buf(8'h3E);
        exp_q.push_back(8'hC5);
        drive_slave(8'hC5, 8, 1, got);
        chk(got == 8'h3E, "R11 full word after abort", got, 8'h3E);
        read_buf();

        // R12: slave ignoring select
        set_slave(4'd5, 1, 0);
        ss_n = 1;
        chk(sdo_oe, "R12 sdo driven", sdo_oe, 1);
        write_buf(8'h9C);
        exp_q.push_back(8'h63);
        drive_slave(8'h63, 8, 0, got);
        chk(got == 8'h9C, "R12 slave sent", got, 8'h9C);
        read_buf();

        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R6 all words seen", exp_q.size(), 0);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule